// File: doc/BRIEF.md
# PLL Settings Register with Reset-Hold Sequencer

This block is the software-visible control and status register of a clock PLL, together with a small sequencer that applies new settings. Software writes four fields into one register: a 5-bit multiplier, a 2-bit output divider select, a 2-bit charge-pump current and a bypass flag. Those writes only change the register itself. The settings reach the PLL only when a write also carries the self-clearing commit bit.

On a commit, the written fields go to the PLL outputs on the next clock edge, and the system reset output goes high. If the commit selects bypass, the reference clock passes straight through and no lock time is needed, so reset is a one-cycle pulse. Otherwise reset stays high for a settle window of `HOLD_CYCLES` reference clocks. With the default of 200000 cycles at 50 MHz, this is 4 ms.

A read-only status field shows the multiplier that the PLL is actually using. After power-on it holds the five strap inputs. After each commit it holds the committed software value.

Top module: `pll_cfg_seq`

## Requirements
- R1: While `rst_n` is low, the stored fields take their reset values and the status field and `pll_mult` load `strap`. The reset values are multiplier 0x1A, charge pump 2'b11, divider select 2'b00 and bypass 0. `pll_div_sel` is 0, `pll_cp` is 3, `pll_bypass` is 0 and `sys_rst` is 0.
- R2: `cfg_rdata` has the following layout:
  - [4:0] is the stored multiplier.
  - [6:5] is the charge pump.
  - [8:7] is the divider select (00 /1, 01 /2, 10 /4, 11 /8).
  - [9] is bypass.
  - [20:16] is the status multiplier.
  - Bit 15 (commit), bits 14:10 and bits 31:21 always read 0.
- R3: A write with bit 15 clear updates only the stored fields. The PLL outputs and the status field keep their values.
- R4: A write with bit 15 set, made while `sys_rst` is low, drives that same write's bits 9:0 onto the PLL outputs and its bits 4:0 into the status field on the next edge. On that edge `sys_rst` goes high.
- R5: A commit with bit 9 set holds `sys_rst` high for exactly one cycle.
- R6: A commit with bit 9 clear holds `sys_rst` high for exactly `HOLD_CYCLES` cycles.
- R7: A commit written while `sys_rst` is high is ignored. The PLL outputs and the length of the running hold do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Power-on reset, active low |
| strap | input | 5 | Power-up multiplier straps |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data |
| pll_mult | output | 5 | Applied multiplier field (factor is value+1) |
| pll_div_sel | output | 2 | Applied output divider select |
| pll_cp | output | 2 | Applied charge-pump current |
| pll_bypass | output | 1 | Applied bypass flag |
| sys_rst | output | 1 | System reset, active high |

## Verification
Read data is combinational from registers. It is therefore due in the same cycle as the clock edge that captures a write, and the bench samples it at the following falling edge. A commit updates the PLL outputs, the status field and `sys_rst` one edge after the strobe is sampled, so these are also checked at that falling edge. The reset-hold length is measured by a falling-edge counter that counts cycles with `sys_rst` high, and that count is compared once `sys_rst` has dropped. Writes without a commit, and commits made while `sys_rst` is high, are checked by confirming that the PLL outputs are unchanged at the next falling edge.

// File: rtl/pll_cfg_seq.sv
module pll_cfg_seq #(
  parameter int HOLD_CYCLES = 200000,
  parameter int MULT_W      = 5,
  parameter int DATA_W      = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MULT_W-1:0] strap,
  input  logic              cfg_we,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  output logic [MULT_W-1:0] pll_mult,
  output logic [1:0]        pll_div_sel,
  output logic [1:0]        pll_cp,
  output logic              pll_bypass,
  output logic              sys_rst
);
  localparam int CNT_W = $clog2(HOLD_CYCLES + 1);
  localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_CYCLES - 1);

  logic [MULT_W-1:0] mult_q;
  logic [1:0]        cp_q, div_q;
  logic              byp_q;
  logic [MULT_W-1:0] stat_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              commit;

  assign commit = cfg_we && cfg_wdata[15] && !sys_rst;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mult_q <= MULT_W'(5'h1A);
      cp_q   <= 2'b11;
      div_q  <= 2'b00;
      byp_q  <= 1'b0;
    end else if (cfg_we) begin
      mult_q <= cfg_wdata[4:0];
      cp_q   <= cfg_wdata[6:5];
      div_q  <= cfg_wdata[8:7];
      byp_q  <= cfg_wdata[9];
    end

  always_ff @(posedge clk)
    if (!rst_n)      stat_q <= strap;
    else if (commit) stat_q <= cfg_wdata[4:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pll_div_sel <= 2'b00;
      pll_cp      <= 2'b11;
      pll_bypass  <= 1'b0;
    end else if (commit) begin
      pll_div_sel <= cfg_wdata[8:7];
      pll_cp      <= cfg_wdata[6:5];
      pll_bypass  <= cfg_wdata[9];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sys_rst <= 1'b0;
      cnt_q   <= '0;
    end else if (commit) begin
      sys_rst <= 1'b1;
      cnt_q   <= cfg_wdata[9] ? '0 : HOLD_LAST;
    end else if (sys_rst) begin
      if (cnt_q == '0) sys_rst <= 1'b0;
      else             cnt_q   <= cnt_q - 1'b1;
    end

  assign pll_mult  = stat_q;
  assign cfg_rdata = {11'b0, stat_q, 6'b0, byp_q, div_q, cp_q, mult_q};
endmodule

// File: rtl/pll_cfg_seq_chk.sv
module pll_cfg_seq_chk #(
  parameter int HOLD_CYCLES = 200000
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_we,
  input logic [31:0] cfg_wdata,
  input logic [31:0] cfg_rdata,
  input logic [4:0]  pll_mult,
  input logic [1:0]  pll_div_sel,
  input logic [1:0]  pll_cp,
  input logic        pll_bypass,
  input logic        sys_rst
);
  logic        go;
  logic [31:0] run;
  logic        run_byp;

  assign go = cfg_we && cfg_wdata[15] && !sys_rst;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      run     <= '0;
      run_byp <= 1'b0;
    end else if (go) begin
      run     <= '0;
      run_byp <= cfg_wdata[9];
    end else if (sys_rst) begin
      run <= run + 1;
    end

  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[31:21] == '0 && cfg_rdata[15:10] == '0);

  p_hold_outputs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> $stable({pll_mult, pll_div_sel, pll_cp, pll_bypass}));

  p_apply_r4: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> sys_rst && pll_mult == $past(cfg_wdata[4:0]) &&
           pll_div_sel == $past(cfg_wdata[8:7]) &&
           pll_cp == $past(cfg_wdata[6:5]) && pll_bypass == $past(cfg_wdata[9]));

  p_bypass_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (go && cfg_wdata[9]) |=> ##1 !sys_rst);

  p_hold_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_rst) |-> run == (run_byp ? 32'd1 : 32'(HOLD_CYCLES)));
endmodule

bind pll_cfg_seq pll_cfg_seq_chk #(.HOLD_CYCLES(HOLD_CYCLES)) i_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
  .cfg_rdata(cfg_rdata), .pll_mult(pll_mult), .pll_div_sel(pll_div_sel),
  .pll_cp(pll_cp), .pll_bypass(pll_bypass), .sys_rst(sys_rst));

// File: tb/test_pll_cfg_seq.sv
module test_pll_cfg_seq;
  localparam int HOLD = 20;
  localparam int NV   = 4;
  localparam logic [63:0] VEC [NV] = '{
    {32'hFFFF7FFF, 32'h000703FF},
    {32'h00000000, 32'h00070000},
    {32'h00000155, 32'h00070155},
    {32'hABCD42AA, 32'h000702AA}
  };

  logic clk = 0, rst_n = 0, cfg_we = 0;
  logic [4:0]  strap = 5'h07;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic [4:0]  pll_mult;
  logic [1:0]  pll_div_sel, pll_cp;
  logic        pll_bypass, sys_rst;
  int n_chk = 0, n_bad = 0, hi_cnt = 0;

  always #10 clk = ~clk;
  always @(negedge clk) if (sys_rst) hi_cnt++;

  pll_cfg_seq #(.HOLD_CYCLES(HOLD)) i_pll_cfg_seq (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [31:0] d);
    cfg_we = 1; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic outs(string req, logic [4:0] m, logic [1:0] dv, logic [1:0] cp, logic b);
    chk(req, {pll_mult, pll_div_sel, pll_cp, pll_bypass}, {m, dv, cp, b});
  endtask

  task automatic do_reset(logic [4:0] s);
    strap = s; rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    #5_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset(5'h07);
    chk("R1 rdata", cfg_rdata, 32'h0007007A);
    outs("R1 outs", 5'h07, 2'd0, 2'd3, 1'b0);
    chk("R1 sys_rst", 32'(sys_rst), 0);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][63:32]);
      chk("R2 readback", cfg_rdata, VEC[i][31:0]);
      outs("R3 no commit", 5'h07, 2'd0, 2'd3, 1'b0);
      chk("R3 sys_rst", 32'(sys_rst), 0);
    end

    hi_cnt = 0;
    wr(32'h00008125);
    outs("R4 applied", 5'h05, 2'd2, 2'd1, 1'b0);
    chk("R4 sys_rst", 32'(sys_rst), 1);
    chk("R4 rdata", cfg_rdata, 32'h00050125);
    repeat (3) @(negedge clk);
    wr(32'h0000821F);
    outs("R7 ignored", 5'h05, 2'd2, 2'd1, 1'b0);
    while (sys_rst) @(negedge clk);
    chk("R6 hold len", 32'(hi_cnt), HOLD);
    chk("R7 hold unchanged", 32'(hi_cnt), HOLD);

    hi_cnt = 0;
    wr(32'h000083CA);
    outs("R4 bypass applied", 5'h0A, 2'd3, 2'd2, 1'b1);
    chk("R2 commit reads 0", cfg_rdata, 32'h000A03CA);
    repeat (3) @(negedge clk);
    chk("R5 pulse len", 32'(hi_cnt), 1);

    do_reset(5'h13);
    chk("R1 strap2 rdata", cfg_rdata, 32'h0013007A);
    outs("R1 strap2 outs", 5'h13, 2'd0, 2'd3, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule